// File: doc/BRIEF.md
# Parallel Dictionary String Decompressor

This block turns a stream of 9-bit codewords back into the byte stream they came from. Its dictionary set has the same shape as the encoder's. Dictionary 0 is virtual and holds every single byte without storage. Four stored dictionaries hold strings of 2, 3, 4 and 5 bytes, with 64, 32, 8 and 8 entries. Each accepted codeword selects one dictionary and one entry in it. The string found there is sent out one byte per cycle, first byte first. In the same cycle the block may add a new string to one dictionary: the previous codeword's string with the first byte of the current string appended.

Codewords enter over a valid/ready port and bytes leave over a valid/ready port. The block accepts a codeword only when it has no bytes left to send, so `in_ready` is low from the acceptance of a good codeword until its last byte has been taken. While `out_valid` is high and `out_ready` is low, the output byte and its last-byte marker hold still and nothing inside changes. A codeword that names a slot never written, or lies beyond the codeword space, is dropped and flagged on a plain one-cycle error pin.

Top module: `pardict_unpack`

## Requirements
- R1: The codeword ranges map to dictionaries as follows: 0..255 to dictionary 0, 256..319 to dictionary 1, 320..351 to dictionary 2, 352..359 to dictionary 3 and 360..367 to dictionary 4. The address is the codeword minus the range base. Dictionary 0 yields the single byte equal to the codeword. Codewords 368..511 are invalid.
- R2: A good codeword from dictionary d produces d+1 bytes on `out_byte`, first byte first. `out_last` is high on the final byte only, and `out_valid` drops in the cycle after that byte is taken.
- R3: While `out_valid` is high and `out_ready` is low, `out_byte` and `out_last` stay stable. `in_ready` stays low for as long as any byte of the current string is pending.
- R4: The first good codeword after reset produces output but inserts nothing.
- R5: Each later good codeword inserts the previous string, extended by the first byte of the current string, into dictionary p+1, where p is the previous good codeword's dictionary.
- R6: Each stored dictionary fills its entries in order from entry 0. After its last entry it wraps to entry 0 and overwrites the oldest string.
- R7: No insert takes place when the previous good codeword came from dictionary 4.
- R8: A codeword that names an unwritten entry or an invalid range raises `bad_code` for exactly one cycle, the cycle after it is accepted. It produces no output and leaves the previous string and the insert target unchanged.
- R9: After reset, `in_ready` is high, `out_valid` is low and `bad_code` is low.
- R10: If a codeword reads the entry that its own insert overwrites in the same cycle, the bytes sent out are the entry's old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Codeword offered |
| in_ready | output | 1 | Block can take a codeword |
| in_code | input | 9 | Codeword |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Decoded byte |
| out_last | output | 1 | Final byte of the current string |
| bad_code | output | 1 | One-cycle pulse for a dropped codeword |

## Verification
Lookup and insert happen in the same accept cycle, and both can target the same dictionary. The bench drives 65 single-byte codewords, which fill dictionary 1 and bring its insert pointer back to entry 0. It then asks for codeword 256 while the pending insert also lands in dictionary 1, entry 0. The bytes sent out must be the old string (R10). A second request for 256 must return the freshly written one (R6). A reference model in the bench holds the same dictionary contents, and a long random run with random output stalls compares every byte against it.

// File: rtl/pardict_pkg.sv
package pardict_pkg;

  localparam int unsigned PD_NDICT = 5;

  // entries per dictionary; dictionary 0 is the virtual single-byte one
  function automatic int unsigned dict_depth(input int unsigned d);
    case (d)
      0: return 256;
      1: return 64;
      2: return 32;
      3: return 8;
      default: return 8;
    endcase
  endfunction

  // first codeword of dictionary d
  function automatic int unsigned dict_base(input int unsigned d);
    int unsigned s;
    s = 0;
    for (int unsigned i = 0; i < d; i++) s += dict_depth(i);
    return s;
  endfunction

endpackage

// File: rtl/pardict_split.sv
module pardict_split
  import pardict_pkg::*;
#(
  parameter int CODE_W = 9,
  parameter int NDICT  = 5,
  parameter int SELW   = 3,
  parameter int AW     = 8
) (
  input  logic [CODE_W-1:0] code,
  output logic [SELW-1:0]   sel,
  output logic [AW-1:0]     addr,
  output logic              in_range
);

  always_comb begin
    sel      = '0;
    addr     = '0;
    in_range = 1'b0;
    for (int unsigned d = 0; d < NDICT; d++) begin
      if (32'(code) >= dict_base(d) && 32'(code) < dict_base(d) + dict_depth(d)) begin
        sel      = SELW'(d);
        addr     = AW'(32'(code) - dict_base(d));
        in_range = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pardict_bank.sv
module pardict_bank #(
  parameter int DEPTH  = 8,
  parameter int LEN    = 2,
  parameter int BYTE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int W     = LEN * BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data
);

  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] filled;
  logic [AW-1:0]    ptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled <= '0;
      ptr    <= '0;
    end else if (wr_en) begin
      filled[ptr] <= 1'b1;
      ptr         <= (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    end
  end

  // read is combinational and sees the contents before this cycle's write
  assign rd_data  = mem[rd_addr];
  assign rd_valid = filled[rd_addr];

  a_r5_slot_filled: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> filled[$past(ptr)]);

  a_r6_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == AW'(DEPTH - 1)) |=> (ptr == '0));

  a_r6_ptr_still: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ptr));

endmodule

// File: rtl/pardict_unpack.sv
module pardict_unpack
  import pardict_pkg::*;
#(
  parameter int CODE_W = 9,
  parameter int BYTE_W = 8,
  parameter int NDICT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_last,
  output logic              bad_code
);

  localparam int MAXLEN = NDICT;
  localparam int SW     = MAXLEN * BYTE_W;
  localparam int DW     = $clog2(NDICT + 1);
  localparam int AW0    = $clog2(dict_depth(0));

  logic [DW-1:0]    sel;
  logic [AW0-1:0]   addr;
  logic             in_range;
  logic [SW-1:0]    rd_str [NDICT];
  logic [NDICT-1:0] rd_ok;
  logic [NDICT-1:1] wr_en;

  logic [SW-1:0]    str_q;
  logic [DW-1:0]    len_q;
  logic [DW-1:0]    idx_q;
  logic [DW-1:0]    tgt_q;
  logic             have_prev;
  logic             busy;
  logic             err_q;

  logic             take, hit_ok;
  logic [SW-1:0]    cur_str, ins_str;

  pardict_split #(
    .CODE_W(CODE_W), .NDICT(NDICT), .SELW(DW), .AW(AW0)
  ) u_split (
    .code(in_code), .sel(sel), .addr(addr), .in_range(in_range)
  );

  assign take    = in_valid && !busy;
  assign hit_ok  = in_range && rd_ok[sel];
  assign cur_str = rd_str[sel];
  // previous string followed by the first byte of the current one
  assign ins_str = str_q | (SW'(cur_str[BYTE_W-1:0]) << (len_q * BYTE_W));

  for (genvar d = 0; d < NDICT; d++) begin : g_dict
    if (d == 0) begin : g_virt
      assign rd_str[0] = SW'(addr[BYTE_W-1:0]);
      assign rd_ok[0]  = 1'b1;
    end else begin : g_bank
      localparam int DEP = dict_depth(d);
      localparam int AWD = $clog2(DEP);
      localparam int LEN = d + 1;
      logic [LEN*BYTE_W-1:0] bank_rd;
      assign wr_en[d] = take && hit_ok && have_prev && (tgt_q == DW'(d));
      pardict_bank #(
        .DEPTH(DEP), .LEN(LEN), .BYTE_W(BYTE_W)
      ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(addr[AWD-1:0]), .rd_data(bank_rd), .rd_valid(rd_ok[d]),
        .wr_en(wr_en[d]), .wr_data(ins_str[LEN*BYTE_W-1:0])
      );
      assign rd_str[d] = SW'(bank_rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      str_q     <= '0;
      len_q     <= '0;
      idx_q     <= '0;
      tgt_q     <= '0;
      have_prev <= 1'b0;
      busy      <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= take && !hit_ok;
      if (take && hit_ok) begin
        str_q     <= cur_str;
        len_q     <= sel + 1'b1;
        idx_q     <= '0;
        tgt_q     <= sel + 1'b1;
        have_prev <= 1'b1;
        busy      <= 1'b1;
      end else if (busy && out_ready) begin
        if (idx_q == len_q - 1'b1) busy <= 1'b0;
        else                       idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign in_ready  = !busy;
  assign out_valid = busy;
  assign out_byte  = str_q[idx_q*BYTE_W +: BYTE_W];
  assign out_last  = busy && (idx_q == len_q - 1'b1);
  assign bad_code  = err_q;

  a_r3_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

  a_r3_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r2_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  a_r8_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code |-> !out_valid);

  a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code |=> (!bad_code || $past(in_valid && in_ready)));

  a_r7_one_insert: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

endmodule

// File: tb/sim_pardict_unpack.sv
module sim_pardict_unpack;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       in_valid = 1'b0, out_ready = 1'b0;
  logic [8:0] in_code = '0;
  logic       in_ready, out_valid, out_last, bad_code;
  logic [7:0] out_byte;

  pardict_unpack u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_last(out_last), .bad_code(bad_code)
  );

  always #(CLK_NS/2) clk = ~clk;

  int total = 0, bad = 0;
  bit done = 1'b0;
  int dep [5] = '{256, 64, 32, 8, 8};
  int bas [5] = '{0, 256, 320, 352, 360};
  logic [39:0] mstr [5][256];
  bit          mval [5][256];
  int          mptr [5];
  logic [39:0] mprev;
  int          mprev_len, mtgt;
  bit          mhave;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int d = 0; d < 5; d++) begin
      mptr[d] = 0;
      for (int e = 0; e < 256; e++) begin mval[d][e] = 1'b0; mstr[d][e] = '0; end
    end
    mprev = '0; mprev_len = 0; mtgt = 0; mhave = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk);
    check(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    check(bad_code == 1'b0, "R9", "bad_code after reset", bad_code, 0);
  endtask

  // called at a negedge; returns at a negedge
  task automatic send(input int code, input string tag);
    int d, a, n, i;
    bit good;
    logic [39:0] s;
    d = -1; a = 0; s = '0;
    for (int k = 0; k < 5; k++)
      if (code >= bas[k] && code < bas[k] + dep[k]) begin d = k; a = code - bas[k]; end
    good = (d == 0) || (d > 0 && mval[d][a]);
    n = d + 1;
    if (good) begin
      s = (d == 0) ? 40'(a) : mstr[d][a];
      if (mhave && mtgt <= 4) begin
        mstr[mtgt][mptr[mtgt]] = mprev | (40'(s[7:0]) << (8 * mprev_len));
        mval[mtgt][mptr[mtgt]] = 1'b1;
        mptr[mtgt] = (mptr[mtgt] + 1) % dep[mtgt];
      end
      mprev = s; mprev_len = n; mtgt = d + 1; mhave = 1'b1;
    end
    in_valid = 1'b1; in_code = 9'(code);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (!good) begin
      check(bad_code == 1'b1, tag, "bad_code on dropped codeword", bad_code, 1);
      check(out_valid == 1'b0, tag, "no output on dropped codeword", out_valid, 0);
      @(negedge clk);
      check(bad_code == 1'b0, tag, "bad_code one cycle only", bad_code, 0);
    end else begin
      i = 0;
      while (i < n) begin
        out_ready = (($urandom % 4) != 0);
        check(out_valid == 1'b1, tag, "out_valid during string", out_valid, 1);
        check(out_byte == s[8*i +: 8], tag, "out_byte", out_byte, int'(s[8*i +: 8]));
        check(out_last == (i == n - 1), tag, "out_last", out_last, int'(i == n - 1));
        check(in_ready == 1'b0, "R3", "in_ready low while bytes pend", in_ready, 0);
        @(negedge clk);
        if (out_ready) i++;
      end
      out_ready = 1'b0;
      check(out_valid == 1'b0, "R2", "out_valid after last byte", out_valid, 0);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c, d, e;
    void'($urandom(32'd2024));
    do_reset();
    // R4 and R8: first code inserts nothing; a dropped code keeps the previous string
    send(65, "R4");
    send(256, "R4");
    send(400, "R1");
    send(66, "R8");
    send(256, "R5");
    send(256, "R5");
    send(257, "R5");
    send(320, "R1");
    send(320, "R5");
    send(352, "R2");
    send(352, "R5");
    send(360, "R2");
    send(361, "R7");
    send(362, "R7");
    send(362, "R7");
    // R6 and R10: fill dictionary 1, wrap, then read the entry being overwritten
    do_reset();
    for (int k = 0; k < 65; k++) send(k, "R6");
    send(256, "R10");
    send(256, "R6");
    send(257, "R6");
    // random run
    for (int k = 0; k < 600; k++) begin
      if (($urandom % 10) == 0) c = int'($urandom % 512);
      else begin
        d = int'($urandom % 5);
        e = int'($urandom % 256) % dep[d];
        if (d == 0) c = e;
        else if (mval[d][e]) c = bas[d] + e;
        else c = int'($urandom % 256);
      end
      send(c, "R5");
      repeat ($urandom % 2) @(negedge clk);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule